// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Access Sequencer

This block sits between a host port that issues 1- to 4-byte reads and writes into a flash window and a byte-wide SPI engine that does the bit shifting. For each host access it looks up the addressed chip select's control word and turns the access into a string of single-byte SPI exchanges. In the framed modes it selects the device, sends an opcode, sends the address high byte first, optionally inserts dummy bytes, moves the data and deselects the device. In user mode it moves only the data bytes and leaves chip-enable handling to software.

Each chip select has its own 32-bit control word, written through a small register port. The word holds the access mode, the opcode, a split dummy count and a stop bit that drives that chip select's active-low enable directly. A configuration word supplies per-chip-select write permission, and a separate input vector picks 3- or 4-byte addressing per chip select. The engine handshake is one byte at a time: the block pulses a start strobe with the byte to send and waits for a done pulse carrying the byte that came back.

Top module: `spi_flash_window_seq`

## Requirements
- R1: After reset every chip-enable output is high (all devices deselected) and host ready is low; each control word resets with its stop bit (bit 2) set and mode 0.
- R2: Control word bits [1:0] choose the mode (0 read, 1 fast read, 2 write, 3 user); in read mode the opcode sent is always 0x03 regardless of control bits [23:16], and in the other framed modes it is bits [23:16].
- R3: In read, fast-read and write modes the block clears the stop bit so the chip enable goes low, sends the opcode, the address bytes most significant first, the dummy bytes if any, the data bytes, then sets the stop bit again before host ready; every byte is exchanged while the chip enable is low.
- R4: The address is 4 bytes (addr[31:0]) when the chip select's bit in the extended-address vector is 1, otherwise 3 bytes (addr[23:0]).
- R5: The dummy count is {bit 14, bits [7:6]} of the control word; in fast-read mode only, count x 8 bytes of 0xFF are sent between address and data; read mode sends none even with a nonzero count.
- R6: Host size field n-1 (2 bits) selects 1 to 4 data bytes; write data leaves least significant byte first and read data is packed little-endian from the returned bytes, unused upper bytes zero; read data bytes transmit 0x00.
- R7: In user mode a write sends only its data bytes and a read sends only 0x00 bytes and captures the replies; no opcode, address or chip-enable change occurs.
- R8: A write to a chip select whose configuration bit (16 + chip-select index) is 0 performs no SPI exchange, returns host ready, and flags no error.
- R9: A write in read or fast-read mode, or a read in write mode, performs no exchange and returns host ready with the mode-error flag set.
- R10: A register write to a control word drives that chip select's enable output from the written bit 2 on the following cycle.
- R11: In fast-read or write mode an opcode field of zero sets the opcode-error flag at host ready, yet the full sequence still runs with opcode 0x00.
- R12: At most one byte is outstanding on the engine port: a new start pulse follows only after the done pulse of the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrCs | input | CS_W | Chip select whose control word is written |
| ctrlWrData | input | 32 | Control word value |
| cfgWord | input | 32 | Configuration word; bit 16+i grants write permission to chip select i |
| extAddr | input | NUM_CS | Per-chip-select 4-byte address enable |
| hostReq | input | 1 | Host access request, accepted when idle |
| hostWr | input | 1 | 1 for write, 0 for read |
| hostCs | input | CS_W | Target chip select |
| hostAddr | input | 32 | Byte address inside the device |
| hostSize | input | 2 | Byte count minus one |
| hostWdata | input | 32 | Write data, byte 0 sent first |
| hostRdata | output | 32 | Read data, valid with host ready |
| hostReady | output | 1 | One-cycle completion pulse |
| modeErr | output | 1 | Access direction not allowed by the mode, valid with host ready |
| opErr | output | 1 | Zero opcode in fast-read or write mode, valid with host ready |
| spiStart | output | 1 | Start one byte exchange |
| spiTxByte | output | 8 | Byte to send, valid with spiStart |
| spiDone | input | 1 | Byte exchange finished |
| spiRxByte | input | 8 | Byte received, valid with spiDone |
| csN | output | NUM_CS | Active-low chip enables |

## Verification
The main function is driven with a plain read carrying a nonzero opcode field and dummy count, which separates the forced 0x03 opcode and the absence of dummies from fast-read behaviour. A 4-byte-address write of 3 bytes and a 3-byte-address fast read with five dummy groups tell the two address widths apart and show byte ordering on both the address and the data side. User-mode reads and writes, a dropped write, direction mismatches and a zero opcode each show a path that must send nothing, or must send without framing, or must still run while flagging. Chip-enable levels are recorded at every exchanged byte, so a framed access that forgot to select its device is visible.

// File: rtl/spi_flash_seq_pkg.sv
package spi_flash_seq_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } seqMode_e;

  typedef enum logic [1:0] {
    BYTE_OPC   = 2'd0,
    BYTE_ADDR  = 2'd1,
    BYTE_DUMMY = 2'd2,
    BYTE_DATA  = 2'd3
  } byteKind_e;

  // Strobes from the sequencer control to the datapath
  typedef struct packed {
    logic      latch;
    logic      csClear;
    logic      csSet;
    logic      spiStart;
    logic      capture;
    byteKind_e kind;
    logic [1:0] idx;
  } seqStrobe_t;

  localparam logic [7:0] READ_OPCODE = 8'h03;
  localparam int STOP_BIT = 2;

endpackage

// File: rtl/spi_flash_seq_dp.sv
module spi_flash_seq_dp
  import spi_flash_seq_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int WE_BASE = 16,
  parameter int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CS_W-1:0]   ctrlWrCs,
  input  logic [31:0]       ctrlWrData,
  input  logic [31:0]       cfgWord,
  input  logic [NUM_CS-1:0] extAddr,
  input  logic              hostWr,
  input  logic [CS_W-1:0]   hostCs,
  input  logic [31:0]       hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  input  seqStrobe_t        strb,
  input  logic [7:0]        spiRxByte,
  output seqMode_e          curMode,
  output logic              curWide,
  output logic              curWritable,
  output logic [2:0]        curDummy,
  output logic              opcodeZero,
  output logic              isWrite,
  output logic [1:0]        sizeM1,
  output logic [7:0]        spiTxByte,
  output logic [31:0]       hostRdata,
  output logic [NUM_CS-1:0] csN
);

  localparam logic [31:0] CTRL_RESET = 32'h1 << STOP_BIT;

  logic [31:0]     ctrlReg [NUM_CS];
  logic [CS_W-1:0] lCs;
  logic            lWr;
  logic [31:0]     lAddr;
  logic [1:0]      lSize;
  logic [31:0]     lWdata;
  logic [31:0]     curCtrl;
  logic [7:0]      opcode;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlReg[i] <= CTRL_RESET;
      end else begin
        if (ctrlWrEn && ctrlWrCs == CS_W'(i)) ctrlReg[i] <= ctrlWrData;
        if (strb.csClear && lCs == CS_W'(i)) ctrlReg[i][STOP_BIT] <= 1'b0;
        if (strb.csSet && lCs == CS_W'(i))   ctrlReg[i][STOP_BIT] <= 1'b1;
      end
    end
    assign csN[i] = ctrlReg[i][STOP_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lCs    <= '0;
      lWr    <= 1'b0;
      lAddr  <= '0;
      lSize  <= '0;
      lWdata <= '0;
    end else if (strb.latch) begin
      lCs    <= hostCs;
      lWr    <= hostWr;
      lAddr  <= hostAddr;
      lSize  <= hostSize;
      lWdata <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             hostRdata <= '0;
    else if (strb.latch)   hostRdata <= '0;
    else if (strb.capture) hostRdata[{strb.idx, 3'b000} +: 8] <= spiRxByte;
  end

  assign curCtrl     = ctrlReg[lCs];
  assign curMode     = seqMode_e'(curCtrl[1:0]);
  assign curWide     = extAddr[lCs];
  assign curWritable = cfgWord[WE_BASE + int'(lCs)];
  assign curDummy    = {curCtrl[14], curCtrl[7:6]};
  assign opcode      = (curMode == MODE_READ) ? READ_OPCODE : curCtrl[23:16];
  assign opcodeZero  = (opcode == 8'h00);
  assign isWrite     = lWr;
  assign sizeM1      = lSize;

  always_comb begin
    unique case (strb.kind)
      BYTE_OPC:   spiTxByte = opcode;
      BYTE_ADDR:  spiTxByte = lAddr[{strb.idx, 3'b000} +: 8];
      BYTE_DUMMY: spiTxByte = 8'hFF;
      default:    spiTxByte = lWr ? lWdata[{strb.idx, 3'b000} +: 8] : 8'h00;
    endcase
  end

  // Framed byte exchanges only happen with the device selected
  p_sel_active_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.spiStart && curMode != MODE_USER) |-> !csN[lCs]);

  // Deselect strobe raises the enable of the active chip select
  p_deselect_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.csSet |=> csN[$past(lCs)]);

  // A register write alone drives the enable from bit 2
  p_sw_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !strb.csClear && !strb.csSet)
      |=> csN[$past(ctrlWrCs)] == $past(ctrlWrData[STOP_BIT]));

endmodule

// File: rtl/spi_flash_seq_ctrl.sv
module spi_flash_seq_ctrl
  import spi_flash_seq_pkg::*;
#(
  parameter int DUMMY_W = 3,
  parameter int CNT_W   = $clog2(((2 ** DUMMY_W) - 1) * 8 + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReq,
  input  seqMode_e           curMode,
  input  logic               curWide,
  input  logic               curWritable,
  input  logic [DUMMY_W-1:0] curDummy,
  input  logic               opcodeZero,
  input  logic               isWrite,
  input  logic [1:0]         sizeM1,
  input  logic               spiDone,
  output seqStrobe_t         strb,
  output logic               hostReady,
  output logic               modeErr,
  output logic               opErr
);

  typedef enum logic [3:0] {
    S_IDLE, S_DECIDE, S_SELECT, S_OPC, S_ADDR, S_DUMMY, S_DATA, S_DESELECT, S_FINISH
  } seqState_e;

  seqState_e        st;
  logic [CNT_W-1:0] cnt;
  logic             inFlight;
  logic             byteState;
  logic             advance;
  logic             dirBad;

  assign byteState = (st == S_OPC) || (st == S_ADDR) || (st == S_DUMMY) || (st == S_DATA);
  assign advance   = inFlight && spiDone;
  assign dirBad    = isWrite != (curMode == MODE_WRITE);
  assign hostReady = (st == S_FINISH);

  always_comb begin
    strb          = '0;
    strb.latch    = (st == S_IDLE) && hostReq;
    strb.csClear  = (st == S_SELECT);
    strb.csSet    = (st == S_DESELECT);
    strb.spiStart = byteState && !inFlight;
    strb.capture  = (st == S_DATA) && advance && !isWrite;
    strb.idx      = cnt[1:0];
    unique case (st)
      S_OPC:   strb.kind = BYTE_OPC;
      S_ADDR:  strb.kind = BYTE_ADDR;
      S_DUMMY: strb.kind = BYTE_DUMMY;
      default: strb.kind = BYTE_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= S_IDLE;
      cnt      <= '0;
      inFlight <= 1'b0;
      modeErr  <= 1'b0;
      opErr    <= 1'b0;
    end else begin
      if (strb.spiStart) inFlight <= 1'b1;
      else if (advance)  inFlight <= 1'b0;
      unique case (st)
        S_IDLE: if (hostReq) begin
          st      <= S_DECIDE;
          modeErr <= 1'b0;
          opErr   <= 1'b0;
        end
        S_DECIDE: begin
          if (isWrite && !curWritable) st <= S_FINISH;
          else if (curMode == MODE_USER) begin
            st  <= S_DATA;
            cnt <= '0;
          end else if (dirBad) begin
            modeErr <= 1'b1;
            st      <= S_FINISH;
          end else st <= S_SELECT;
        end
        S_SELECT: begin
          st <= S_OPC;
          if (opcodeZero) opErr <= 1'b1;
        end
        S_OPC: if (advance) begin
          st  <= S_ADDR;
          cnt <= curWide ? CNT_W'(3) : CNT_W'(2);
        end
        S_ADDR: if (advance) begin
          if (cnt == '0) begin
            if (curMode == MODE_FAST && curDummy != '0) begin
              st  <= S_DUMMY;
              cnt <= CNT_W'({curDummy, 3'b000}) - CNT_W'(1);
            end else begin
              st  <= S_DATA;
              cnt <= '0;
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        S_DUMMY: if (advance) begin
          if (cnt == '0) st <= S_DATA;
          else cnt <= cnt - CNT_W'(1);
        end
        S_DATA: if (advance) begin
          if (cnt[1:0] == sizeM1) st <= (curMode == MODE_USER) ? S_FINISH : S_DESELECT;
          else cnt <= cnt + CNT_W'(1);
        end
        S_DESELECT: st <= S_FINISH;
        default:    st <= S_IDLE;
      endcase
    end
  end

  p_one_byte_r12: assert property (@(posedge clk) disable iff (!rstN)
    strb.spiStart |=> !strb.spiStart);

  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady);

  p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_DECIDE && isWrite && !curWritable) |=> (hostReady && !modeErr));

  p_mode_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_DECIDE && !(isWrite && !curWritable) && curMode != MODE_USER && dirBad)
      |=> (hostReady && modeErr && !strb.spiStart));

endmodule

// File: rtl/spi_flash_window_seq.sv
module spi_flash_window_seq
  import spi_flash_seq_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int WE_BASE = 16,
  parameter int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CS_W-1:0]   ctrlWrCs,
  input  logic [31:0]       ctrlWrData,
  input  logic [31:0]       cfgWord,
  input  logic [NUM_CS-1:0] extAddr,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [CS_W-1:0]   hostCs,
  input  logic [31:0]       hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              hostReady,
  output logic              modeErr,
  output logic              opErr,
  output logic              spiStart,
  output logic [7:0]        spiTxByte,
  input  logic              spiDone,
  input  logic [7:0]        spiRxByte,
  output logic [NUM_CS-1:0] csN
);

  seqStrobe_t strb;
  seqMode_e   curMode;
  logic       curWide;
  logic       curWritable;
  logic [2:0] curDummy;
  logic       opcodeZero;
  logic       isWrite;
  logic [1:0] sizeM1;

  spi_flash_seq_dp #(.NUM_CS(NUM_CS), .WE_BASE(WE_BASE), .CS_W(CS_W)) u_dp (
    .clk, .rstN, .ctrlWrEn, .ctrlWrCs, .ctrlWrData, .cfgWord, .extAddr,
    .hostWr, .hostCs, .hostAddr, .hostSize, .hostWdata, .strb, .spiRxByte,
    .curMode, .curWide, .curWritable, .curDummy, .opcodeZero, .isWrite,
    .sizeM1, .spiTxByte, .hostRdata, .csN
  );

  spi_flash_seq_ctrl #(.DUMMY_W(3)) u_ctrl (
    .clk, .rstN, .hostReq, .curMode, .curWide, .curWritable, .curDummy,
    .opcodeZero, .isWrite, .sizeM1, .spiDone, .strb, .hostReady, .modeErr, .opErr
  );

  assign spiStart = strb.spiStart;

endmodule

// File: tb/sim_spi_flash_window_seq.sv
`timescale 1ns/1ps
module sim_spi_flash_window_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [1:0]  ctrlWrCs = '0;
  logic [31:0] ctrlWrData = '0;
  logic [31:0] cfgWord = '0;
  logic [3:0]  extAddr = '0;
  logic        hostReq = 1'b0;
  logic        hostWr = 1'b0;
  logic [1:0]  hostCs = '0;
  logic [31:0] hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostReady, modeErr, opErr, spiStart;
  logic [7:0]  spiTxByte;
  logic        spiDone = 1'b0;
  logic [7:0]  spiRxByte = '0;
  logic [3:0]  csN;

  always #2.5 clk = ~clk;

  spi_flash_window_seq u0 (
    .clk, .rstN, .ctrlWrEn, .ctrlWrCs, .ctrlWrData, .cfgWord, .extAddr,
    .hostReq, .hostWr, .hostCs, .hostAddr, .hostSize, .hostWdata,
    .hostRdata, .hostReady, .modeErr, .opErr, .spiStart, .spiTxByte,
    .spiDone, .spiRxByte, .csN
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Byte engine model: logs each byte and the enables, answers with its log index
  logic [7:0] txLog [0:511];
  logic [3:0] csLog [0:511];
  int logCount = 0;
  int overlap = 0;
  bit pending = 0;
  int delay = 0;
  int rxPos = 0;

  always @(negedge clk) begin
    spiDone = 1'b0;
    if (spiStart) begin
      if (pending) overlap++;
      txLog[logCount] = spiTxByte;
      csLog[logCount] = csN;
      rxPos = logCount;
      logCount++;
      pending = 1;
      delay = 2;
    end else if (pending) begin
      if (delay == 0) begin
        spiDone = 1'b1;
        spiRxByte = 8'(8'h10 + rxPos);
        pending = 0;
      end else delay--;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(input logic [1:0] mode, input logic [7:0] opc,
                                         input logic [2:0] dmy, input logic stop);
    return {8'h00, opc, 1'b0, dmy[2], 6'b0, dmy[1:0], 3'b0, stop, mode};
  endfunction

  task automatic writeCtrl(input int cs, input logic [31:0] val);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrCs = 2'(cs); ctrlWrData = val;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  int base;
  int nBytes;
  logic [31:0] rdOut;
  logic mErr, oErr;

  task automatic runTxn(input int cs, input bit wr, input logic [31:0] addr,
                        input int size, input logic [31:0] wd);
    bit done = 0;
    @(negedge clk);
    base = logCount;
    hostReq = 1'b1; hostWr = wr; hostCs = 2'(cs); hostAddr = addr;
    hostSize = 2'(size - 1); hostWdata = wd;
    @(negedge clk);
    hostReq = 1'b0;
    for (int t = 0; t < 3000 && !done; t++) begin
      if (hostReady) done = 1;
      else @(negedge clk);
    end
    chk("R3 host ready reached", 32'(done), 32'd1);
    rdOut = hostRdata; mErr = modeErr; oErr = opErr;
    nBytes = logCount - base;
  endtask

  function automatic logic [7:0] rxAt(input int k);
    return 8'(8'h10 + base + k);
  endfunction

  task automatic t_reset();
    chk("R1 enables high after reset", 32'(csN), 32'hF);
    chk("R1 ready low after reset", 32'(hostReady), 32'd0);
  endtask

  task automatic t_read_mode();
    logic [7:0] exp [0:7] = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00};
    writeCtrl(0, mkCtrl(2'd0, 8'hAB, 3'd7, 1'b1));
    runTxn(0, 1'b0, 32'h00123456, 4, 32'h0);
    chk("R5 read mode sends no dummies", 32'(nBytes), 32'd8);
    for (int k = 0; k < 8; k++) begin
      chk("R2 R3 read mode byte order", 32'(txLog[base + k]), 32'(exp[k]));
      chk("R3 enable low per byte", 32'(csLog[base + k][0]), 32'd0);
    end
    chk("R6 read data little-endian", rdOut, {rxAt(7), rxAt(6), rxAt(5), rxAt(4)});
    chk("R3 deselected after access", 32'(csN[0]), 32'd1);
    chk("R9 no mode error", 32'(mErr), 32'd0);
  endtask

  task automatic t_wide_write();
    logic [7:0] exp [0:7] = '{8'h02, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hCC, 8'hDD, 8'hEE};
    cfgWord = 32'h1 << 17;
    extAddr = 4'b0010;
    writeCtrl(1, mkCtrl(2'd2, 8'h02, 3'd0, 1'b1));
    runTxn(1, 1'b1, 32'hA1B2C3D4, 3, 32'h00EEDDCC);
    chk("R4 four address bytes", 32'(nBytes), 32'd8);
    for (int k = 0; k < 8; k++)
      chk("R4 R6 write byte order", 32'(txLog[base + k]), 32'(exp[k]));
    chk("R11 no opcode error", 32'(oErr), 32'd0);
    chk("R3 deselected after write", 32'(csN[1]), 32'd1);
  endtask

  task automatic t_dropped_write();
    cfgWord = 32'h1 << 16;
    runTxn(1, 1'b1, 32'h00000010, 2, 32'h0000BEEF);
    chk("R8 dropped write sends nothing", 32'(nBytes), 32'd0);
    chk("R8 dropped write no error", 32'(mErr), 32'd0);
    chk("R8 enable untouched", 32'(csN[1]), 32'd1);
  endtask

  task automatic t_fast_read();
    writeCtrl(2, mkCtrl(2'd1, 8'h0B, 3'd5, 1'b1));
    runTxn(2, 1'b0, 32'h00000010, 1, 32'h0);
    chk("R5 fast read byte count", 32'(nBytes), 32'd45);
    chk("R2 fast read opcode", 32'(txLog[base]), 32'h0B);
    chk("R4 three-byte address low byte", 32'(txLog[base + 3]), 32'h10);
    for (int k = 4; k < 44; k++)
      chk("R5 dummy byte value", 32'(txLog[base + k]), 32'hFF);
    chk("R6 single byte read", rdOut, {24'h0, rxAt(44)});
  endtask

  task automatic t_invalid();
    runTxn(0, 1'b1, 32'h0, 1, 32'h55);
    chk("R9 write in read mode flagged", 32'(mErr), 32'd1);
    chk("R9 write in read mode silent", 32'(nBytes), 32'd0);
    runTxn(1, 1'b0, 32'h0, 1, 32'h0);
    chk("R9 read in write mode flagged", 32'(mErr), 32'd1);
    chk("R9 read in write mode silent", 32'(nBytes), 32'd0);
  endtask

  task automatic t_user();
    cfgWord = (32'h1 << 16) | (32'h1 << 19);
    writeCtrl(3, mkCtrl(2'd3, 8'h00, 3'd0, 1'b0));
    chk("R10 software select", 32'(csN[3]), 32'd0);
    runTxn(3, 1'b1, 32'h00ABCDEF, 3, 32'h00332211);
    chk("R7 user write raw bytes only", 32'(nBytes), 32'd3);
    chk("R7 user byte 0", 32'(txLog[base]), 32'h11);
    chk("R7 user byte 2", 32'(txLog[base + 2]), 32'h33);
    chk("R7 enable unchanged", 32'(csN[3]), 32'd0);
    runTxn(3, 1'b0, 32'h0, 2, 32'h0);
    chk("R7 user read byte count", 32'(nBytes), 32'd2);
    chk("R7 user read sends zero", 32'(txLog[base + 1]), 32'h00);
    chk("R7 user read data", rdOut, {16'h0, rxAt(1), rxAt(0)});
    writeCtrl(3, mkCtrl(2'd3, 8'h00, 3'd0, 1'b1));
    chk("R10 software deselect", 32'(csN[3]), 32'd1);
  endtask

  task automatic t_zero_opcode();
    cfgWord = 32'h1 << 17;
    writeCtrl(1, mkCtrl(2'd2, 8'h00, 3'd0, 1'b1));
    runTxn(1, 1'b1, 32'h01020304, 1, 32'h0000007E);
    chk("R11 opcode error flagged", 32'(oErr), 32'd1);
    chk("R11 sequence still runs", 32'(nBytes), 32'd6);
    chk("R11 zero opcode sent", 32'(txLog[base]), 32'h00);
    chk("R11 data byte sent", 32'(txLog[base + 5]), 32'h7E);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_mode();
    t_wide_write();
    t_dropped_write();
    t_fast_read();
    t_invalid();
    t_user();
    t_zero_opcode();
    chk("R12 one byte outstanding", 32'(overlap), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule